// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits next to a processor that announces each bus transfer only through a three-bit active-low status code. It watches that code and turns it into separate memory and I/O read and write strobes, an interrupt acknowledge strobe, and early write strobes for slow slaves. It also produces an address latch pulse, a transceiver direction signal and a transceiver data enable.

A transfer begins when the status leaves the idle (passive) code. It ends when the status goes back to passive. No other strobe from the processor is used. A command enable input masks every command strobe at once, so another master can own the command lines.

Top module: `bus_cmd_gen`

## Requirements
- R1: During reset, and in the first clock period after reset, every command strobe is high (inactive) and `ale`, `dt_tx` and `den` are low. An asynchronous reset in the middle of a transfer returns all outputs to this state at once.
- R2: The status value `stat_n[2:0]` = {S2,S1,S0} is decoded as follows. 000 is interrupt acknowledge. 001 is I/O read. 010 is I/O write. 011 is halt. 100 is code fetch. 101 is memory read. 110 is memory write. 111 is passive. An I/O read drives `io_rd_n`, and an I/O write drives `io_wr_n`.
- R3: The status may change from passive to a transfer code at a rising edge. In that case `ale` is high for exactly the next clock period, and that period is the address phase.
- R4: A halt code seen after passive starts no transfer. Passive status alone produces no `ale` and no command.
- R5: Normal command strobes go low one clock period after the address phase. They stay low until the edge at which passive status is sampled.
- R6: When `ADV_EARLY`=1, `adv_mem_wr_n` or `adv_io_wr_n` goes low in the address phase, in the same period as `ale`. It stays low until the transfer ends.
- R7: At most one of `mem_rd_n`, `mem_wr_n`, `io_rd_n` and `io_wr_n` is low at any time.
- R8: All commands go inactive, and `den` and `dt_tx` go low, in the clock period after passive status is sampled. This holds even when passive is sampled during the address phase.
- R9: `dt_tx` is high from the address phase to the end of a write transfer. It is low for read, code fetch and interrupt acknowledge transfers. `den` is high in the command phase of every decoded transfer.
- R10: While `cmd_en` is low, every command strobe, including the early and acknowledge strobes, is held high without any clock delay. `ale`, `dt_tx` and `den` do not depend on `cmd_en`.
- R11: During a transfer, a change from one non-passive code to another does not start a new transfer. The transfer type latched at the start is kept.
- R12: A code fetch drives `mem_rd_n`, the same strobe as a memory read. An interrupt acknowledge drives only `inta_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_n | input | 3 | Processor status code {S2,S1,S0} |
| cmd_en | input | 1 | Command enable; low masks all command strobes |
| ale | output | 1 | Address latch enable pulse |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| adv_mem_wr_n | output | 1 | Early memory write command, active low |
| adv_io_wr_n | output | 1 | Early I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| dt_tx | output | 1 | Transceiver direction, high means transmit |
| den | output | 1 | Transceiver data enable, active high |

## Verification
The hardest case to reach from the ports is a status that jumps straight from one transfer code to another with no passive clock in between. A correct processor never does this, so the stimulus table places a write code directly after a read transfer has started. It then checks that the read strobe stays low and that no new address pulse appears. A second hard case is a passive code in the very first clock after the start. This is driven directly so that the address phase ends without ever reaching the command phase.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   typedef enum logic [2:0] {
      CK_INTA = 3'b000,
      CK_IORD = 3'b001,
      CK_IOWR = 3'b010,
      CK_HALT = 3'b011,
      CK_CODE = 3'b100,
      CK_MRD  = 3'b101,
      CK_MWR  = 3'b110,
      CK_PASV = 3'b111
   } cyc_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_CMD  = 2'd2
   } cyc_phase_e;

   function automatic logic kind_is_write(cyc_kind_e k);
      return (k == CK_MWR) || (k == CK_IOWR);
   endfunction

   function automatic logic kind_is_mem_rd(cyc_kind_e k);
      return (k == CK_MRD) || (k == CK_CODE);
   endfunction

endpackage

// File: rtl/bcg_stat_watch.sv
module bcg_stat_watch
   import bcg_pkg::*;
#(
   parameter int STAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_n,
   output logic              start,
   output logic              pasv_now
);

   localparam logic [STAT_W-1:0] PASV_CODE = {STAT_W{1'b1}};

   logic [STAT_W-1:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PASV_CODE;
      else        st_q <= stat_n;
   end

   always_comb begin
      pasv_now = (stat_n == PASV_CODE);
      start    = (st_q == PASV_CODE) && !pasv_now &&
                 (cyc_kind_e'(stat_n) != CK_HALT);
   end

   // R4: a halt code never counts as the start of a transfer
   a_r4_halt_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_kind_e'(stat_n) == CK_HALT) |-> !start);

endmodule

// File: rtl/bcg_sequencer.sv
module bcg_sequencer
   import bcg_pkg::*;
#(
   parameter int STAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_n,
   input  logic              start,
   input  logic              pasv_now,
   output cyc_phase_e        phase,
   output cyc_kind_e         kind
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         kind  <= CK_PASV;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_ADDR;
               kind  <= cyc_kind_e'(stat_n);
            end
            PH_ADDR: phase <= pasv_now ? PH_IDLE : PH_CMD;
            PH_CMD:  if (pasv_now) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R8: passive status during a transfer closes it on the next edge
   a_r8_close_on_pasv: assert property (@(posedge clk) disable iff (!rst_n)
      (pasv_now && phase != PH_IDLE) |=> (phase == PH_IDLE));

   // R11: the latched type holds while a transfer is open
   a_r11_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !pasv_now) |=> $stable(kind));

   // R3: the address phase lasts a single clock
   a_r3_addr_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR) |=> (phase != PH_ADDR));

endmodule

// File: rtl/bcg_strobe_gen.sv
module bcg_strobe_gen
   import bcg_pkg::*;
#(
   parameter bit ADV_EARLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  cyc_phase_e phase,
   input  cyc_kind_e  kind,
   input  logic       cmd_en,
   output logic       ale,
   output logic       mem_rd_n,
   output logic       mem_wr_n,
   output logic       io_rd_n,
   output logic       io_wr_n,
   output logic       adv_mem_wr_n,
   output logic       adv_io_wr_n,
   output logic       inta_n,
   output logic       dt_tx,
   output logic       den
);

   logic in_cyc, in_cmd;
   logic mrd, mwr, iord, iowr, inta, amwr, aiowr;

   always_comb begin
      in_cyc = (phase != PH_IDLE);
      in_cmd = (phase == PH_CMD);
      mrd    = in_cmd && kind_is_mem_rd(kind);
      mwr    = in_cmd && (kind == CK_MWR);
      iord   = in_cmd && (kind == CK_IORD);
      iowr   = in_cmd && (kind == CK_IOWR);
      inta   = in_cmd && (kind == CK_INTA);
   end

   generate
      if (ADV_EARLY) begin : g_adv_early
         assign amwr  = in_cyc && (kind == CK_MWR);
         assign aiowr = in_cyc && (kind == CK_IOWR);
      end else begin : g_adv_normal
         assign amwr  = mwr;
         assign aiowr = iowr;
      end
   endgenerate

   always_comb begin
      ale          = (phase == PH_ADDR);
      dt_tx        = in_cyc && kind_is_write(kind);
      den          = in_cmd;
      mem_rd_n     = !(cmd_en && mrd);
      mem_wr_n     = !(cmd_en && mwr);
      io_rd_n      = !(cmd_en && iord);
      io_wr_n      = !(cmd_en && iowr);
      adv_mem_wr_n = !(cmd_en && amwr);
      adv_io_wr_n  = !(cmd_en && aiowr);
      inta_n       = !(cmd_en && inta);
   end

   // R7: never two of the four main commands at once
   a_r7_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}) <= 1);

   // R10: a low enable leaves every command strobe idle
   a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_en |-> (&{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n,
                     adv_mem_wr_n, adv_io_wr_n, inta_n}));

   // R9: data enable is only given in the command phase
   a_r9_den_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> !den);

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
   import bcg_pkg::*;
#(
   parameter int STAT_W    = 3,
   parameter bit ADV_EARLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_n,
   input  logic              cmd_en,
   output logic              ale,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic              io_rd_n,
   output logic              io_wr_n,
   output logic              adv_mem_wr_n,
   output logic              adv_io_wr_n,
   output logic              inta_n,
   output logic              dt_tx,
   output logic              den
);

   generate
      if (STAT_W != 3) begin : g_bad_width
         $error("bus_cmd_gen: STAT_W must be 3");
      end
   endgenerate

   logic       start, pasv_now;
   cyc_phase_e phase;
   cyc_kind_e  kind;

   bcg_stat_watch #(.STAT_W(STAT_W)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_n   (stat_n),
      .start    (start),
      .pasv_now (pasv_now)
   );

   bcg_sequencer #(.STAT_W(STAT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_n   (stat_n),
      .start    (start),
      .pasv_now (pasv_now),
      .phase    (phase),
      .kind     (kind)
   );

   bcg_strobe_gen #(.ADV_EARLY(ADV_EARLY)) u_strobe (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase        (phase),
      .kind         (kind),
      .cmd_en       (cmd_en),
      .ale          (ale),
      .mem_rd_n     (mem_rd_n),
      .mem_wr_n     (mem_wr_n),
      .io_rd_n      (io_rd_n),
      .io_wr_n      (io_wr_n),
      .adv_mem_wr_n (adv_mem_wr_n),
      .adv_io_wr_n  (adv_io_wr_n),
      .inta_n       (inta_n),
      .dt_tx        (dt_tx),
      .den          (den)
   );

   // R3: the latch pulse is one clock wide
   a_r3_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R5: an enabled read after the address phase drives the read strobe
   a_r5_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && !dt_tx && cmd_en && !pasv_now && kind_is_mem_rd(kind)) |=>
      (!cmd_en || !mem_rd_n));

endmodule

// File: tb/test_bus_cmd_gen.sv
module test_bus_cmd_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] stat_n = 3'b111;
   logic       cmd_en = 1'b1;
   logic       ale, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
   logic       adv_mem_wr_n, adv_io_wr_n, inta_n, dt_tx, den;
   int         n_chk = 0;
   int         n_fail = 0;

   always #10 clk = ~clk;

   bus_cmd_gen i_bus_cmd_gen (
      .clk(clk), .rst_n(rst_n), .stat_n(stat_n), .cmd_en(cmd_en),
      .ale(ale), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
      .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .adv_mem_wr_n(adv_mem_wr_n),
      .adv_io_wr_n(adv_io_wr_n), .inta_n(inta_n), .dt_tx(dt_tx), .den(den)
   );

   // bit order: ale, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n,
   //            adv_mem_wr_n, adv_io_wr_n, inta_n, dt_tx, den
   localparam logic [9:0] IDLE = 10'b0111111100;
   localparam logic [9:0] ADDR = 10'b1111111100;

   function automatic logic [9:0] outs();
      return {ale, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n,
              adv_mem_wr_n, adv_io_wr_n, inta_n, dt_tx, den};
   endfunction

   // {stat_n, cmd_en, expected outputs after the edge}
   localparam int NV = 33;
   localparam logic [13:0] VEC [NV] = '{
      {3'b111, 1'b1, IDLE},          // R1 idle
      {3'b101, 1'b1, ADDR},          // R3 read start
      {3'b101, 1'b1, 10'b0011111101},// R5 read command
      {3'b101, 1'b1, 10'b0011111101},// R7 held
      {3'b111, 1'b1, IDLE},          // R8
      {3'b110, 1'b1, 10'b1111101110},// R6 early mem write
      {3'b110, 1'b1, 10'b0101101111},// R9 write direction
      {3'b111, 1'b1, IDLE},          // R8
      {3'b010, 1'b1, 10'b1111110110},// R6 early io write
      {3'b010, 1'b1, 10'b0111010111},// R2 io write
      {3'b111, 1'b1, IDLE},          // R8
      {3'b001, 1'b1, ADDR},          // R3
      {3'b001, 1'b1, 10'b0110111101},// R2 io read
      {3'b111, 1'b1, IDLE},          // R8
      {3'b000, 1'b1, ADDR},          // R3
      {3'b000, 1'b1, 10'b0111111001},// R12 inta
      {3'b111, 1'b1, IDLE},          // R8
      {3'b100, 1'b1, ADDR},          // R3
      {3'b100, 1'b1, 10'b0011111101},// R12 code fetch
      {3'b111, 1'b1, IDLE},          // R8
      {3'b011, 1'b1, IDLE},          // R4 halt
      {3'b011, 1'b1, IDLE},          // R4
      {3'b111, 1'b1, IDLE},          // R4
      {3'b110, 1'b0, 10'b1111111110},// R10 masked
      {3'b110, 1'b0, 10'b0111111111},// R10 masked
      {3'b110, 1'b1, 10'b0101101111},// R10 unmasked
      {3'b111, 1'b1, IDLE},          // R8
      {3'b101, 1'b1, ADDR},          // R3
      {3'b110, 1'b1, 10'b0011111101},// R11 code jump
      {3'b110, 1'b1, 10'b0011111101},// R11
      {3'b111, 1'b1, IDLE},          // R8
      {3'b101, 1'b1, ADDR},          // R3
      {3'b111, 1'b1, IDLE}           // R8 passive in address phase
   };

   function automatic string req_of(int i);
      case (i)
         0:                         return "R1";
         2:                         return "R5";
         3:                         return "R7";
         5, 8:                      return "R6";
         6:                         return "R9";
         9, 12:                     return "R2";
         15, 18:                    return "R12";
         20, 21, 22:                return "R4";
         23, 24, 25:                return "R10";
         28, 29:                    return "R11";
         1, 11, 14, 17, 27, 31:     return "R3";
         default:                   return "R8";
      endcase
   endfunction

   task automatic check(string req, logic [9:0] exp);
      logic [9:0] act;
      act = outs();
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs %b expected %b", req, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired, R8 transfer never closed");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", IDLE);                // in reset
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R1", IDLE);                // first period after reset

      for (int i = 0; i < NV; i++) begin
         stat_n = VEC[i][13:11];
         cmd_en = VEC[i][10];
         @(posedge clk); @(negedge clk);
         check(req_of(i), VEC[i][9:0]);
      end

      // R10: enable acts without a clock on a held read
      stat_n = 3'b101;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      check("R5", 10'b0011111101);
      cmd_en = 1'b0; #1;
      check("R10", 10'b0111111101);
      cmd_en = 1'b1; #1;
      check("R10", 10'b0011111101);
      stat_n = 3'b111;
      @(posedge clk); @(negedge clk);
      check("R8", IDLE);

      // R1: asynchronous reset in the middle of a write
      stat_n = 3'b110;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      check("R9", 10'b0101101111);
      rst_n = 1'b0; stat_n = 3'b111; #1;
      check("R1", IDLE);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R1", IDLE);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule